// File: doc/BRIEF.md
# Byte-wise OTP Memory Programming Sequencer

This controller writes an image into an 8-bit-wide one-time-programmable memory, one byte at a time, by driving the memory's chip-enable, output-enable, program-strobe, address and data pins. A host starts it with a first and a last address. The host then supplies one data byte per address through a valid/ready handshake. For every byte the sequencer applies a program pulse of fixed width and then a verify read. It repeats the pulse and the verify until the byte reads back as intended. There is no extra pulse once the verify matches.

Erased cells read as 1, and a pulse can only clear bits. A target that needs a 0 turned back into a 1 can therefore never verify. Such a byte, or any byte that does not verify within a parameterised pulse budget, stops the run with an error that names the address. The sequencer raises an enable for the high programming supply before the first pulse and keeps it up through the last verify, with a settle interval on each side. The supply switching itself lies outside the block.

Top module: `eprog_seq`

## Requirements
- R1: After reset the block is idle. vpp_en=0, mem_ce_n=1, mem_oe_n=1, mem_pgm_n=1, mem_dq_oe=0, wr_ready=0, busy=0, done=0 and err=0.
- R2: Every program pulse holds mem_pgm_n low for exactly CLK_KHZ*PULSE_US/1000 consecutive cycles (at least 1). Throughout the pulse mem_ce_n=0, mem_oe_n=1, vpp_en=1, mem_dq_oe=1, and mem_dq_out equals the target byte of the current address.
- R3: Every pulse is followed directly by a verify read lasting VERIFY_CYC cycles. During the verify mem_ce_n=0, mem_oe_n=0, mem_pgm_n=1, mem_dq_oe=0 and vpp_en=1. The byte on mem_dq_in is compared in the last verify cycle. mem_dq_oe is never high while mem_oe_n is low.
- R4: For a target other than 0xFF, pulses on one address repeat until a verify matches. The number of pulses on that address equals the number the memory needs, and no pulse follows the matching verify.
- R5: A target of 0xFF is first checked with a verify read and no pulse. If the cell reads 0xFF, the address receives zero pulses.
- R6: If a verify still mismatches after MAX_PULSES pulses on one address, the run stops. err goes high, err_addr holds that address, no further byte is accepted and done does not pulse. This includes targets that need a 0 turned into a 1.
- R7: vpp_en is high for at least SETTLE_CYC cycles before the first pulse of a run. It stays high for at least SETTLE_CYC cycles after the last verify, then falls to 0 until the next start.
- R8: Addresses run upward from start_addr to end_addr inclusive. Exactly one byte is taken per address, when wr_valid and wr_ready are both high at a clock edge. If end_addr is below start_addr, only start_addr is programmed.
- R9: A successful run ends with done high for exactly one cycle. err stays clear on success and is cleared when a new run starts.
- R10: start has no effect while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a run when idle |
| start_addr | input | AW | First address of the run |
| end_addr | input | AW | Last address of the run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when a run completes without error |
| err | output | 1 | Run stopped on a byte that would not verify |
| err_addr | output | AW | Address of the failing byte |
| wr_valid | input | 1 | Host offers a data byte |
| wr_data | input | 8 | Data byte for the current address |
| wr_ready | output | 1 | Sequencer accepts a byte |
| vpp_en | output | 1 | Enable for the high programming supply |
| mem_addr | output | AW | Memory address pins |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_pgm_n | output | 1 | Memory program strobe, active low |
| mem_dq_out | output | 8 | Data driven to the memory data pins |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data read from the memory data pins |

## Verification
The bench builds the block with AW=6, CLK_KHZ=100, PULSE_US=100, MAX_PULSES=4, SETTLE_CYC=3 and VERIFY_CYC=2. These values give a 10-cycle pulse, so many multi-pulse bytes fit in one run. The 64-byte space makes the whole memory model visible. A budget of 4 pulses can be beaten by a memory that needs 5, which reaches the retry-limit error without long runs. The three-cycle settle keeps the supply timing measurable at each end.

// File: rtl/eprog_pkg.sv
package eprog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RAMP,
    ST_FETCH,
    ST_BURN,
    ST_CHECK,
    ST_DRAIN
  } seq_state_t;

  // clock cycles in one program pulse, never below one
  function automatic int unsigned burn_cycles(input int unsigned clk_khz,
                                              input int unsigned pulse_us);
    longint unsigned p;
    p = (longint'(clk_khz) * longint'(pulse_us)) / 64'd1000;
    return (p < 64'd1) ? 1 : int'(p);
  endfunction

  // an all-ones target can only be left alone, so it is read before any pulse
  function automatic logic read_first(input logic [7:0] tgt);
    return tgt == 8'hFF;
  endfunction

endpackage

// File: rtl/eprog_timer.sv
module eprog_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R2: the interval timer runs down one step per cycle
  assert_timer_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/eprog_walk.sv
module eprog_walk #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] last,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          at_end
);
  logic [AW-1:0] end_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr  <= '0;
      end_q <= '0;
    end else if (load) begin
      addr  <= first;
      end_q <= last;
    end else if (step) begin
      addr  <= addr + 1'b1;
    end
  end

  // an end below the start ends the run after the first byte
  assign at_end = (addr >= end_q);

  // R8: addresses advance by one per accepted byte
  assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (addr == $past(addr) + 1'b1));

endmodule

// File: rtl/eprog_seq.sv
module eprog_seq
  import eprog_pkg::*;
#(
  parameter int AW         = 18,
  parameter int CLK_KHZ    = 250000,
  parameter int PULSE_US   = 100,
  parameter int MAX_PULSES = 25,
  parameter int SETTLE_CYC = 8,
  parameter int VERIFY_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] err_addr,
  input  logic          wr_valid,
  input  logic [7:0]    wr_data,
  output logic          wr_ready,
  output logic          vpp_en,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_pgm_n,
  output logic [7:0]    mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [7:0]    mem_dq_in
);
  localparam int unsigned BURN_N = burn_cycles(CLK_KHZ, PULSE_US);
  localparam int unsigned SET_N  = (SETTLE_CYC < 1) ? 1 : SETTLE_CYC;
  localparam int unsigned VER_N  = (VERIFY_CYC < 1) ? 1 : VERIFY_CYC;
  localparam int unsigned T1     = (BURN_N > SET_N) ? BURN_N : SET_N;
  localparam int unsigned TMAX   = (T1 > VER_N) ? T1 : VER_N;
  localparam int TW = $clog2(TMAX + 1);
  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam int SW = $clog2(SET_N + 1);

  seq_state_t    st, nxt;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          walk_load, walk_step, walk_end;
  logic [AW-1:0] cur_addr;
  logic [7:0]    tgt;
  logic [PW-1:0] pcnt;
  logic          fail;

  // named events
  logic take, burn_end, chk_end, chk_pass, give_up, drain_end, launch;
  assign launch    = (st == ST_IDLE) && start;
  assign take      = (st == ST_FETCH) && wr_valid;
  assign burn_end  = (st == ST_BURN) && tmr_zero;
  assign chk_end   = (st == ST_CHECK) && tmr_zero;
  assign chk_pass  = chk_end && (mem_dq_in == tgt);
  assign give_up   = chk_end && !chk_pass && (pcnt >= PW'(MAX_PULSES));
  assign drain_end = (st == ST_DRAIN) && tmr_zero;

  eprog_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

  eprog_walk #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(walk_load), .first(start_addr),
    .last(end_addr), .step(walk_step), .addr(cur_addr), .at_end(walk_end)
  );

  always_comb begin
    nxt       = st;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    walk_load = 1'b0;
    walk_step = 1'b0;
    case (st)
      ST_IDLE: if (launch) begin
        nxt = ST_RAMP; walk_load = 1'b1; tmr_load = 1'b1; tmr_val = TW'(SET_N - 1);
      end
      ST_RAMP: if (tmr_zero) nxt = ST_FETCH;
      ST_FETCH: if (take) begin
        tmr_load = 1'b1;
        if (read_first(wr_data)) begin
          nxt = ST_CHECK; tmr_val = TW'(VER_N - 1);
        end else begin
          nxt = ST_BURN;  tmr_val = TW'(BURN_N - 1);
        end
      end
      ST_BURN: if (burn_end) begin
        nxt = ST_CHECK; tmr_load = 1'b1; tmr_val = TW'(VER_N - 1);
      end
      ST_CHECK: if (chk_end) begin
        if (chk_pass && !walk_end) begin
          nxt = ST_FETCH; walk_step = 1'b1;
        end else if (chk_pass || give_up) begin
          nxt = ST_DRAIN; tmr_load = 1'b1; tmr_val = TW'(SET_N - 1);
        end else begin
          nxt = ST_BURN;  tmr_load = 1'b1; tmr_val = TW'(BURN_N - 1);
        end
      end
      ST_DRAIN: if (drain_end) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      tgt      <= '0;
      pcnt     <= '0;
      fail     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      err_addr <= '0;
    end else begin
      st   <= nxt;
      done <= drain_end && !fail;
      if (launch) begin
        fail <= 1'b0;
        err  <= 1'b0;
      end
      if (take) begin
        tgt  <= wr_data;
        pcnt <= '0;
      end
      if (burn_end) pcnt <= pcnt + 1'b1;
      if (give_up) begin
        fail     <= 1'b1;
        err_addr <= cur_addr;
      end
      if (drain_end && fail) err <= 1'b1;
    end
  end

  assign busy       = (st != ST_IDLE);
  assign vpp_en     = (st != ST_IDLE);
  assign wr_ready   = (st == ST_FETCH);
  assign mem_addr   = cur_addr;
  assign mem_ce_n   = !((st == ST_BURN) || (st == ST_CHECK));
  assign mem_oe_n   = (st != ST_CHECK);
  assign mem_pgm_n  = (st != ST_BURN);
  assign mem_dq_oe  = (st == ST_BURN);
  assign mem_dq_out = tgt;

  // observation counters for the timing assertions
  logic [TW-1:0] burn_len;
  logic [SW-1:0] vpp_age, since_chk;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burn_len  <= '0;
      vpp_age   <= '0;
      since_chk <= '0;
    end else begin
      burn_len  <= !mem_pgm_n ? ((burn_len == TW'(TMAX)) ? burn_len : burn_len + 1'b1) : '0;
      vpp_age   <= vpp_en ? ((vpp_age == SW'(SET_N)) ? vpp_age : vpp_age + 1'b1) : '0;
      since_chk <= !mem_oe_n ? '0 :
                   ((since_chk == SW'(SET_N)) ? since_chk : since_chk + 1'b1);
    end
  end

  assert_burn_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_pgm_n) |-> (burn_len == TW'(BURN_N)));

  assert_verify_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_pgm_n) |-> (!mem_oe_n && !mem_ce_n && !mem_dq_oe && vpp_en));

  assert_retry_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_pgm_n) |-> (pcnt < PW'(MAX_PULSES)));

  assert_supply_ramp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_pgm_n) |-> (vpp_age >= SW'(SET_N)));

  assert_supply_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vpp_en) |-> (since_chk >= SW'(SET_N)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !drain_end) |=> busy);

endmodule

// File: tb/eprog_seq_test.sv
module eprog_seq_test;
  localparam int AW = 6;
  localparam int N = 64;
  localparam int MAXP = 4;
  localparam int SET = 3;
  localparam int VER = 2;
  localparam int PULSE = (100 * 100) / 1000;

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [AW-1:0] start_addr = '0, end_addr = '0;
  logic busy, done, err, wr_ready, vpp_en;
  logic [AW-1:0] err_addr, mem_addr;
  logic wr_valid = 0;
  logic [7:0] wr_data = '0;
  logic mem_ce_n, mem_oe_n, mem_pgm_n, mem_dq_oe;
  logic [7:0] mem_dq_out, mem_dq_in;

  always #2 clk = ~clk;

  logic [7:0] mem [N];
  logic [7:0] tgt [N];
  logic [7:0] mem0 [N];
  int need [N];
  int pulses [N];
  int exp_p [N];

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? mem[mem_addr] : 8'h5A;

  eprog_seq #(.AW(AW), .CLK_KHZ(100), .PULSE_US(100), .MAX_PULSES(MAXP),
              .SETTLE_CYC(SET), .VERIFY_CYC(VER)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .end_addr(end_addr), .busy(busy), .done(done), .err(err), .err_addr(err_addr),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready), .vpp_en(vpp_en),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_pgm_n(mem_pgm_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  int total = 0, bad = 0;
  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // memory model and port monitor, sampled on the falling edge
  int lowrun = 0, width_bad = 0, drive_bad = 0, settle_bad = 0, drain_bad = 0;
  int vpp_run = 0, since_chk = 0, done_cnt = 0, done_bad = 0, takes = 0, order_bad = 0;
  int next_take = 0;
  logic [AW-1:0] burn_addr = '0;
  logic [7:0] burn_data = '0;
  logic prev_done = 0, prev_vpp = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_pgm_n) begin
        lowrun++;
        burn_addr = mem_addr;
        burn_data = mem_dq_out;
        if (mem_ce_n || !mem_oe_n || !vpp_en || !mem_dq_oe || mem_dq_out != tgt[mem_addr])
          drive_bad++;
        if (lowrun == 1 && vpp_run < SET) settle_bad++;
      end else if (lowrun > 0) begin
        if (lowrun != PULSE) width_bad++;
        pulses[burn_addr]++;
        if (pulses[burn_addr] >= need[burn_addr]) mem[burn_addr] = mem[burn_addr] & burn_data;
        lowrun = 0;
        if (mem_oe_n || mem_ce_n || mem_dq_oe) drive_bad++;
      end
      if (!mem_oe_n && mem_dq_oe) drive_bad++;
      if (!vpp_en && prev_vpp && since_chk < SET) drain_bad++;
      if (!mem_oe_n) since_chk = 0;
      else if (vpp_en) since_chk++;
      vpp_run = vpp_en ? vpp_run + 1 : 0;
      prev_vpp = vpp_en;
      if (done) begin
        done_cnt++;
        if (prev_done) done_bad++;
      end
      prev_done = done;
      if (wr_valid && wr_ready) begin
        takes++;
        if (int'(mem_addr) != next_take) order_bad++;
        next_take++;
      end
    end
  end

  // host byte source
  bit host_go = 0;
  int host_a = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (host_go) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        if (host_go) begin
          wr_valid = 1;
          wr_data = tgt[host_a];
          while (!wr_ready && host_go) @(negedge clk);
          if (host_go) begin
            @(negedge clk);
            host_a++;
          end
          wr_valid = 0;
        end
      end
    end
  end

  // expected pulses for one byte, and whether it verifies
  function automatic int exp_pulses(input logic [7:0] m, input logic [7:0] t,
                                    input int n, output bit ok);
    ok = 1;
    if (t == 8'hFF) begin
      if (m == 8'hFF) return 0;
      ok = 0; return MAXP;
    end
    if (m == t) return 1;
    if (((t & ~m) == 8'h00) && n <= MAXP) return n;
    ok = 0;
    return MAXP;
  endfunction

  task automatic prep_random();
    for (int a = 0; a < N; a++) begin
      int k;
      mem[a] = ($urandom_range(0, 1) == 0) ? 8'hFF : 8'($urandom);
      k = $urandom_range(0, 19);
      if (k < 11)      tgt[a] = mem[a] & 8'($urandom);
      else if (k < 14) tgt[a] = 8'hFF;
      else if (k < 16) tgt[a] = mem[a];
      else             tgt[a] = 8'($urandom);
      need[a] = ($urandom_range(0, 9) == 0) ? MAXP + 1 : $urandom_range(1, 3);
    end
  endtask

  task automatic run_case(input int s, input int e, input bit kick, input string tag);
    int last, fail_a, cyc;
    bit ok, good_all, flag;
    logic [7:0] exp_mem [N];
    last = (e < s) ? s : e;
    fail_a = -1;
    for (int a = 0; a < N; a++) begin
      mem0[a] = mem[a]; exp_p[a] = 0; pulses[a] = 0;
    end
    for (int a = s; a <= last; a++) begin
      exp_p[a] = exp_pulses(mem[a], tgt[a], need[a], ok);
      if (!ok) begin fail_a = a; break; end
    end
    for (int a = 0; a < N; a++)
      exp_mem[a] = (exp_p[a] > 0 && exp_p[a] >= need[a]) ? (mem0[a] & tgt[a]) : mem0[a];
    width_bad = 0; drive_bad = 0; settle_bad = 0; drain_bad = 0;
    done_cnt = 0; done_bad = 0; takes = 0; order_bad = 0; next_take = s;
    @(negedge clk);
    start_addr = AW'(s); end_addr = AW'(e); start = 1;
    host_a = s;
    @(negedge clk);
    start = 0;
    host_go = 1;
    if (kick) begin
      repeat (20) @(negedge clk);
      start_addr = AW'(0); end_addr = AW'(N - 1); start = 1;
      @(negedge clk);
      start = 0;
    end
    cyc = 0;
    flag = 0;
    while (!flag && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (done || (err && !busy)) flag = 1;
    end
    host_go = 0;
    repeat (3) @(negedge clk);
    check(flag, "R9", {tag, " run finished"}, int'(flag), 1);
    check(err == (fail_a >= 0), "R6", {tag, " err flag"}, int'(err), int'(fail_a >= 0));
    if (fail_a >= 0) begin
      check(int'(err_addr) == fail_a, "R6", {tag, " err_addr"}, int'(err_addr), fail_a);
      check(done_cnt == 0, "R6", {tag, " no done on error"}, done_cnt, 0);
    end else begin
      check(done_cnt == 1 && done_bad == 0, "R9", {tag, " one-cycle done"}, done_cnt, 1);
    end
    check(busy == 0 && vpp_en == 0, "R7", {tag, " supply off when idle"}, int'(vpp_en), 0);
    good_all = 1;
    for (int a = 0; a < N; a++) if (pulses[a] != exp_p[a]) begin
      good_all = 0;
      $display("  addr %0d pulses=%0d exp=%0d", a, pulses[a], exp_p[a]);
    end
    check(good_all, "R4", {tag, " pulse counts per address"}, int'(good_all), 1);
    good_all = 1;
    for (int a = 0; a < N; a++) if (mem[a] !== exp_mem[a]) good_all = 0;
    check(good_all, "R4", {tag, " final memory image"}, int'(good_all), 1);
    check(takes == ((fail_a >= 0) ? fail_a : last) - s + 1 && order_bad == 0, "R8",
          {tag, " bytes taken in order"}, takes, ((fail_a >= 0) ? fail_a : last) - s + 1);
    check(width_bad == 0, "R2", {tag, " pulse width"}, width_bad, 0);
    check(drive_bad == 0, "R3", {tag, " pin states in pulse/verify"}, drive_bad, 0);
    check(settle_bad == 0 && drain_bad == 0, "R7", {tag, " supply settle"},
          settle_bad + drain_bad, 0);
  endtask

  bit wd_hit = 0;
  initial begin
    repeat (190000) @(posedge clk);
    wd_hit = 1;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd4242);
    for (int a = 0; a < N; a++) begin
      mem[a] = 8'hFF; tgt[a] = 8'hFF; need[a] = 1; pulses[a] = 0;
    end
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!vpp_en && mem_ce_n && mem_oe_n && mem_pgm_n && !mem_dq_oe && !wr_ready
          && !busy && !done && !err, "R1", "reset outputs", int'(vpp_en), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!busy && !vpp_en, "R1", "idle after reset", int'(busy), 0);

    // R5: all-ones targets on erased cells get no pulse
    for (int a = 0; a < N; a++) begin mem[a] = 8'hFF; tgt[a] = 8'hFF; need[a] = 1; end
    run_case(2, 6, 0, "R5 blank skip");

    // R4: multi-pulse bytes
    for (int a = 10; a < 14; a++) begin mem[a] = 8'hFF; tgt[a] = 8'(a * 7); need[a] = a - 9; end
    run_case(10, 13, 0, "R4 multi-pulse");

    // R6: 0 -> 1 can never verify
    mem[20] = 8'hF0; tgt[20] = 8'hFF; mem[21] = 8'h0F; tgt[21] = 8'h3C; need[21] = 1;
    run_case(21, 22, 0, "R6 needs one bit");

    // R6: needs more pulses than the budget
    mem[30] = 8'hFF; tgt[30] = 8'h00; need[30] = 1;
    mem[31] = 8'hFF; tgt[31] = 8'h12; need[31] = MAXP + 1;
    run_case(30, 33, 0, "R6 budget");
    check(mem[32] == 8'hFF, "R6", "byte after failure untouched", int'(mem[32]), 255);

    // R8: end below start programs only the start address
    mem[40] = 8'hFF; tgt[40] = 8'hA5; need[40] = 2;
    run_case(40, 3, 0, "R8 reversed range");

    // R9: error cleared by a new successful run
    mem[50] = 8'hFF; tgt[50] = 8'h01; need[50] = 1;
    run_case(50, 50, 0, "R9 err clears");

    // R10: start while busy is ignored
    for (int a = 0; a < N; a++) begin mem[a] = 8'hFF; tgt[a] = 8'h00; need[a] = 2; end
    run_case(5, 9, 1, "R10 restart ignored");

    for (int r = 0; r < 24; r++) begin
      int s, len;
      prep_random();
      s = $urandom_range(0, N - 1);
      len = $urandom_range(0, 11);
      run_case(s, (s + len > N - 1) ? N - 1 : s + len, 0, "random");
    end

    if (!wd_hit) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule